// File: doc/BRIEF.md
# Two-Stage Probe Concentrator

This block lets a small debug region watch a chosen handful of internal signals out of a much larger pool. It takes N probe inputs, partitioned into K equal groups of G bits (one group per source unit, narrower units padded to G), and routes any selected subset of them onto an M-wide tap bus, where M is smaller than N. The order of selected bits on the bus follows a fixed packing rule. That order carries no meaning for the consumer, and software cannot choose it.

Routing works in two registered stages. In the first stage each group has its own compaction switch, which packs the group's selected bits into a contiguous run at the low end of that group's output. In the second stage an enabled AND/OR merge places each group's run on the shared bus, starting at the first bus position that no earlier group has claimed. Software writes a per-group selection mask into shadow registers through an address/data port and then issues a commit pulse. From the commit, the block derives the per-group bus offsets and enable masks and keeps them in local flip-flops. A sticky flag reports a commit that asks for more than M bits in total.

Top module: `probe_concentrator`

## Requirements
- R1: After reset, `tap_vld`, `tap_bus` and `cfg_err` are all 0, and every selection mask is 0.
- R2: Within group g, a probe bit `probe_in[g*G+i]` is selected when bit i of the group's live mask is 1. Selected bits of one group appear on the bus as a contiguous run, in ascending order of i.
- R3: Groups are placed in ascending group index. The run of group g starts at bus position equal to the total number of selected bits in groups 0..g-1. Bus positions that no group claims read 0.
- R4: Selected bits whose computed bus position is M or higher are dropped, and bits placed at lower positions are unaffected.
- R5: When a commit makes the total selected bit count exceed M, `cfg_err` goes to 1 two clock edges after the edge that samples the commit. It then stays 1 until reset, even if later commits are legal.
- R6: A write (`cfg_we`=1) stores `cfg_wdata` as the shadow mask of group `cfg_addr` and has no effect on routing until a commit. A commit copies all shadow masks into the live masks. When a write and a commit occur in the same cycle, the commit copies the shadow content from before that write.
- R7: `tap_vld` equals `probe_vld` delayed by exactly 2 clock cycles. `tap_bus` shows the routing of the `probe_in` sampled 2 edges earlier.
- R8: Each probe sample is routed entirely with the live masks in force at the edge that samples it, including the sample taken at the same edge as a commit. No sample mixes old and new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_in | input | NUM_GROUPS*GROUP_W | Probe pool, group g in bits [g*GROUP_W +: GROUP_W] |
| probe_vld | input | 1 | Marks a meaningful probe sample |
| cfg_we | input | 1 | Shadow mask write strobe |
| cfg_addr | input | clog2(NUM_GROUPS) | Group index of the write |
| cfg_wdata | input | GROUP_W | Selection mask to store |
| cfg_commit | input | 1 | Copy shadow masks to live routing |
| tap_bus | output | BUS_W | Concentrated probe bus |
| tap_vld | output | 1 | Valid flag aligned with tap_bus |
| cfg_err | output | 1 | Sticky over-subscription flag |

## Verification
Suppose the compaction or the offset state is wrong. A bit then lands at the wrong bus position, a bus slot collides with another group, or a slot is missing, and this shows on `tap_bus` two cycles after the affected sample. Suppose instead the commit path is wrong, for example offsets update in a different cycle from the masks, or a write leaks past the shadow. Then the samples taken right around a commit show bits from a mixed configuration, so directed commits are issued while samples are flowing. Errors in the over-subscription logic show on `cfg_err` within two edges of the commit, or as a flag that clears when it should stay set.

// File: rtl/probe_concentrator_pkg.sv
package probe_concentrator_pkg;
  // fixed input-to-output delay in clock cycles
  localparam int PIPE_LATENCY = 2;

  // bound a bus offset to the bus width
  function automatic int clamp_offset(input int off, input int lim);
    return (off < lim) ? off : lim;
  endfunction
endpackage

// File: rtl/pc_cfg_bank.sv
module pc_cfg_bank #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int BUS_W      = 8,
  localparam int AW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int OW = $clog2(BUS_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [GROUP_W-1:0]            wdata,
  input  logic                          commit,
  output logic [NUM_GROUPS*GROUP_W-1:0] live_mask,
  output logic [NUM_GROUPS*OW-1:0]      off_flat,
  output logic [NUM_GROUPS*BUS_W-1:0]   en_flat,
  output logic                          err
);
  import probe_concentrator_pkg::*;

  logic [NUM_GROUPS*GROUP_W-1:0] shadow_q, live_q;
  logic [NUM_GROUPS*OW-1:0]      off_q, off_d;
  logic [NUM_GROUPS*BUS_W-1:0]   en_q, en_d;
  logic                          commit_d, err_q;
  int                            total_d;

  always_comb begin
    int run;
    int cnt;
    run   = 0;
    off_d = '0;
    en_d  = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      cnt = $countones(live_q[g*GROUP_W +: GROUP_W]);
      off_d[g*OW +: OW] = OW'(clamp_offset(run, BUS_W));
      for (int p = 0; p < BUS_W; p++)
        en_d[g*BUS_W + p] = (p >= run) && (p < run + cnt);
      run = run + cnt;
    end
    total_d = run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      live_q   <= '0;
      off_q    <= '0;
      en_q     <= '0;
      commit_d <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (commit) live_q <= shadow_q;
      if (we && (int'(addr) < NUM_GROUPS))
        shadow_q[addr*GROUP_W +: GROUP_W] <= wdata;
      commit_d <= commit;
      if (commit_d) begin
        off_q <= off_d;
        en_q  <= en_d;
        if (total_d > BUS_W) err_q <= 1'b1;
      end
    end
  end

  assign live_mask = live_q;
  assign off_flat  = off_q;
  assign en_flat   = en_q;
  assign err       = err_q;

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R6
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(live_q));
endmodule

// File: rtl/pc_group_compact.sv
module pc_group_compact #(
  parameter int GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] din,
  input  logic [GROUP_W-1:0] mask,
  output logic [GROUP_W-1:0] comp_q
);
  logic [GROUP_W-1:0] comp_d;
  logic               ready_q;

  always_comb begin
    int p;
    p      = 0;
    comp_d = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      if (mask[i]) begin
        comp_d[p] = din[i];
        p = p + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      comp_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      comp_q  <= comp_d;
      ready_q <= 1'b1;
    end
  end

  // R2
  compact_ones_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> ($countones(comp_q) == $countones($past(din & mask))));
endmodule

// File: rtl/pc_bus_merge.sv
module pc_bus_merge #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int BUS_W      = 8,
  localparam int OW = $clog2(BUS_W + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_GROUPS*GROUP_W-1:0] comp_flat,
  input  logic [NUM_GROUPS*OW-1:0]      off_flat,
  input  logic [NUM_GROUPS*BUS_W-1:0]   en_flat,
  input  logic                          vld_in,
  output logic [BUS_W-1:0]              bus_q,
  output logic                          vld_q
);
  logic [BUS_W-1:0] bus_d;

  always_comb begin
    int o;
    bus_d = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      o = int'(off_flat[g*OW +: OW]);
      for (int p = 0; p < BUS_W; p++) begin
        if ((p >= o) && (p - o < GROUP_W) && en_flat[g*BUS_W + p])
          bus_d[p] = bus_d[p] | comp_flat[g*GROUP_W + p - o];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      vld_q <= 1'b0;
    end else begin
      bus_q <= bus_d;
      vld_q <= vld_in;
    end
  end

  for (genvar a = 0; a < NUM_GROUPS; a++) begin : g_pair_a
    for (genvar b = a + 1; b < NUM_GROUPS; b++) begin : g_pair_b
      // R3
      en_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (en_flat[a*BUS_W +: BUS_W] & en_flat[b*BUS_W +: BUS_W]) == '0);
    end
  end
endmodule

// File: rtl/probe_concentrator.sv
module probe_concentrator #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int BUS_W      = 8,
  localparam int N  = NUM_GROUPS * GROUP_W,
  localparam int AW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int OW = $clog2(BUS_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       probe_in,
  input  logic               probe_vld,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [GROUP_W-1:0] cfg_wdata,
  input  logic               cfg_commit,
  output logic [BUS_W-1:0]   tap_bus,
  output logic               tap_vld,
  output logic               cfg_err
);
  logic [N-1:0]                 live_mask, comp_flat;
  logic [NUM_GROUPS*OW-1:0]     off_flat;
  logic [NUM_GROUPS*BUS_W-1:0]  en_flat;
  logic                         v1_q;
  logic [1:0]                   warm_q;

  pc_cfg_bank #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .BUS_W(BUS_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .commit(cfg_commit), .live_mask(live_mask), .off_flat(off_flat),
    .en_flat(en_flat), .err(cfg_err)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_stage1
    pc_group_compact #(.GROUP_W(GROUP_W)) cmp_i (
      .clk(clk), .rst(rst),
      .din(probe_in[g*GROUP_W +: GROUP_W]),
      .mask(live_mask[g*GROUP_W +: GROUP_W]),
      .comp_q(comp_flat[g*GROUP_W +: GROUP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      warm_q <= '0;
    end else begin
      v1_q <= probe_vld;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  pc_bus_merge #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .BUS_W(BUS_W)) mrg_i (
    .clk(clk), .rst(rst), .comp_flat(comp_flat), .off_flat(off_flat),
    .en_flat(en_flat), .vld_in(v1_q), .bus_q(tap_bus), .vld_q(tap_vld)
  );

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (tap_vld == $past(probe_vld, 2)));

  // R4
  bus_width_chk: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> ($countones(tap_bus) <= $countones($past(probe_in, 2))));
endmodule

// File: tb/probe_concentrator_tb_top.sv
module probe_concentrator_tb_top;
  localparam int K  = 4;
  localparam int G  = 8;
  localparam int M  = 8;
  localparam int N  = K * G;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] probe_in = '0;
  logic probe_vld = 1'b0, cfg_we = 1'b0, cfg_commit = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [G-1:0] cfg_wdata = '0;
  logic [M-1:0] tap_bus;
  logic tap_vld, cfg_err;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [N-1:0] shad_m, live_m;
  logic [M-1:0] exp_bus [2];
  logic         exp_vld [2];
  logic         err_exp, bad_d1, bad_d2;

  always #2 clk = ~clk;

  probe_concentrator #(.NUM_GROUPS(K), .GROUP_W(G), .BUS_W(M)) dut_i (
    .clk(clk), .rst(rst), .probe_in(probe_in), .probe_vld(probe_vld),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_commit(cfg_commit), .tap_bus(tap_bus), .tap_vld(tap_vld),
    .cfg_err(cfg_err)
  );

  function automatic logic [M-1:0] route(input logic [N-1:0] d, input logic [N-1:0] msk);
    logic [M-1:0] r;
    int p;
    r = '0;
    p = 0;
    for (int g = 0; g < K; g++)
      for (int i = 0; i < G; i++)
        if (msk[g*G+i]) begin
          if (p < M) r[p] = d[g*G+i];
          p++;
        end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    shad_m = '0; live_m = '0; err_exp = 0; bad_d1 = 0; bad_d2 = 0;
    exp_bus[0] = '0; exp_bus[1] = '0; exp_vld[0] = 0; exp_vld[1] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; probe_in = '0; probe_vld = 0; cfg_we = 0; cfg_commit = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic cycle(input string req, input logic [N-1:0] d, input logic v,
                       input logic we, input logic [AW-1:0] a,
                       input logic [G-1:0] w, input logic cm);
    @(negedge clk);
    chk(req, 32'(tap_bus), 32'(exp_bus[1]));
    chk("R7", 32'(tap_vld), 32'(exp_vld[1]));
    err_exp = err_exp | bad_d2;
    chk("R5", 32'(cfg_err), 32'(err_exp));
    bad_d2 = bad_d1;
    probe_in = d; probe_vld = v; cfg_we = we; cfg_addr = a; cfg_wdata = w; cfg_commit = cm;
    exp_bus[1] = exp_bus[0]; exp_vld[1] = exp_vld[0];
    exp_bus[0] = route(d, live_m); exp_vld[0] = v;
    bad_d1 = 0;
    if (cm) begin
      live_m = shad_m;
      bad_d1 = ($countones(shad_m) > M);
    end
    if (we) shad_m[a*G +: G] = w;
  endtask

  task automatic data(input string req, input int n);
    for (int j = 0; j < n; j++) cycle(req, {$urandom, $urandom}, 1'($urandom), 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [G-1:0] w);
    cycle("R6", {$urandom, $urandom}, 1, 1, a, w, 0);
  endtask

  task automatic commit_now(input string req);
    cycle(req, {$urandom, $urandom}, 1, 0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    do_reset();
    // R1: reset state
    @(negedge clk);
    chk("R1", 32'(tap_vld), 0);
    chk("R1", 32'(tap_bus), 0);
    chk("R1", 32'(cfg_err), 0);
    data("R1", 3);  // zero masks give a zero bus

    // R2: compaction within groups
    wr(0, 8'h0F); wr(2, 8'hA5); commit_now("R2");
    data("R2", 8);
    cycle("R2", 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
    cycle("R2", 32'h00A5_000F, 1, 0, 0, 0, 0);
    data("R2", 3);

    // R6: shadow write without commit does not disturb routing
    wr(1, 8'hFF); data("R6", 6);
    // R8 and R4: commit during traffic, total 16 > 8 overflows
    commit_now("R8"); data("R8", 3);
    data("R4", 6);
    chk("R5", 32'(cfg_err), 1);

    // R5: sticky after a legal commit
    wr(0, 8'h01); wr(1, 8'h00); wr(2, 8'h00); commit_now("R5");
    data("R5", 5);
    chk("R5", 32'(cfg_err), 1);

    // R1: reset clears the flag and the masks
    do_reset();
    @(negedge clk);
    chk("R1", 32'(cfg_err), 0);
    data("R1", 3);

    // R3: group order and offsets, with empty group in between
    wr(3, 8'h81); wr(0, 8'h80); wr(1, 8'h06); commit_now("R3");
    data("R3", 8);
    // R6: write and commit in same cycle commit old shadow
    cycle("R6", {$urandom, $urandom}, 1, 1, 2, 8'hFF, 1);
    data("R6", 5);

    // R4: exactly M selections then one more
    wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00); commit_now("R4");
    data("R4", 4);
    wr(3, 8'h10); commit_now("R4"); data("R4", 5);

    // random traffic with random reconfiguration
    for (int j = 0; j < 600; j++) begin
      int r;
      r = int'($urandom % 20);
      cycle("R2", {$urandom, $urandom}, 1'($urandom), r < 3, AW'($urandom),
            G'($urandom & $urandom & $urandom), r == 5);
    end
    data("R7", 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule